// File: doc/BRIEF.md
# Dual Programmable-Tap Delay Line

This block delays an 8-bit data word by a programmable number of clock cycles. The word is handled as two independent 4-bit lanes. Each lane runs through its own fixed chain of seventeen registers. A selector picks one stage of that chain and loads it into an output register. Both lanes share a single clock and a single set of controls.

A 4-bit length code sets the delay, which runs from 3 to 18 cycles. A pin-mode bit decides how the two lanes use that code:

- With the bit clear, both lanes use the programmed delay.
- With the bit set, the upper lane stays at the longest delay and the lower lane still follows the code.

The controls pass through a register before they steer the selector. Changing them never touches the data already held in the chains. The output carries straight on from the newly chosen tap, with no flush and no refill.

Top module: `dtl_delay_line`

## Requirements
- R1: While `rst_n` is low, every chain register, the output register and the control register are cleared. `dout` reads 0, and the registered controls read as code 0 with the pin-mode bit clear.
- R2: With the pin-mode bit at 0 and a steady length code N, each lane reproduces its input N+3 clock edges later. The code is read as an unsigned 4-bit number.
- R3: The delay limits are exact. Code 0 gives 3 cycles, the shortest path: first stage, second stage, then the output register. Code 15 gives 18 cycles.
- R4: With the pin-mode bit at 1, the upper lane (`dout[7:4]`) is delayed by 18 cycles for every code value. The lower lane (`dout[3:0]`) still follows the code as in R2.
- R5: The length code and the pin-mode bit are captured on a rising clock edge. The first output register load steered by a new value happens on the following edge.
- R6: A change of code or mode leaves all seventeen chain stages of both lanes untouched. From the first load steered by the new control, the output shows data already in flight, at the new delay.
- R7: The lanes are fixed by bit position: `din[3:0]` feeds only `dout[3:0]`, and `din[7:4]` feeds only `dout[7:4]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| din | input | 8 | Two 4-bit data lanes, lower lane in bits 3:0 |
| len_code | input | 4 | Length code N, giving a delay of N+3 cycles |
| pin_mode | input | 1 | 1 holds the upper lane at the 18-cycle delay |
| dout | output | 8 | Delayed lanes, driven straight from the output registers |

## Verification
The properties compare the output against samples of the input taken a few cycles back, and against stage contents one cycle back. They therefore assume the inputs are defined on every clock edge once reset is released. The checker also waits out a warm-up count after reset, so that every stage and the control register hold post-reset data before any property is evaluated. The bench meets these assumptions in three ways:

- It drives every input from a defined value on the falling edge, including during reset.
- It holds the data at zero during reset.
- It keeps the length code inside its 4-bit range, so every selected tap lies within the chain.

// File: rtl/dtl_pkg.sv
package dtl_pkg;

    // Lane width and control widths shared by every unit of the delay line
    localparam int DTL_NIB_W     = 4;
    localparam int DTL_CODE_W    = 4;
    localparam int DTL_MIN_DELAY = 3;

    // Behaviour of the topmost lane
    typedef enum logic {
        MODE_SHARED    = 1'b0,
        MODE_PIN_UPPER = 1'b1
    } dtl_mode_e;

endpackage

// File: rtl/dtl_ctrl_reg.sv
module dtl_ctrl_reg
    import dtl_pkg::*;
#(
    parameter int CODE_W = DTL_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              mode_in,
    output logic [CODE_W-1:0] code_q,
    output dtl_mode_e         mode_q
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        dtl_mode_e         mode;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    // Next state: the controls are sampled on every edge
    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.code = code_in;
        ctrl_d.mode = dtl_mode_e'(mode_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{code: '0, mode: MODE_SHARED};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign code_q = ctrl_q.code;
    assign mode_q = ctrl_q.mode;

endmodule

// File: rtl/dtl_chain.sv
module dtl_chain
    import dtl_pkg::*;
#(
    parameter int W   = DTL_NIB_W,
    parameter int LEN = 17
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [W-1:0]           lane_in,
    output logic [LEN-1:0][W-1:0]  stages
);

    typedef struct packed {
        logic [LEN-1:0][W-1:0] stg;
    } chain_t;

    chain_t chain_d, chain_q;

    // Unconditional shift: the controls never reach this chain
    always_comb begin
        chain_d        = chain_q;
        chain_d.stg[0] = lane_in;
        for (int k = 1; k < LEN; k++) begin
            chain_d.stg[k] = chain_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign stages = chain_q.stg;

endmodule

// File: rtl/dtl_tap_out.sv
module dtl_tap_out
    import dtl_pkg::*;
#(
    parameter int W     = DTL_NIB_W,
    parameter int LEN   = 17,
    parameter int IDX_W = $clog2(LEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LEN-1:0][W-1:0]  stages,
    input  logic [IDX_W-1:0]       sel,
    output logic [W-1:0]           lane_out
);

    typedef struct packed {
        logic [W-1:0] out;
    } tap_t;

    tap_t tap_d, tap_q;

    // Tap selector; an index past the end falls back to the last stage
    always_comb begin
        tap_d = tap_q;
        if (int'(sel) < LEN) begin
            tap_d.out = stages[sel];
        end else begin
            tap_d.out = stages[LEN-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else begin
            tap_q <= tap_d;
        end
    end

    assign lane_out = tap_q.out;

endmodule

// File: rtl/dtl_delay_line.sv
module dtl_delay_line
    import dtl_pkg::*;
#(
    parameter int NIB_W     = DTL_NIB_W,
    parameter int NUM_PATHS = 2,
    parameter int CODE_W    = DTL_CODE_W,
    parameter int MIN_DELAY = DTL_MIN_DELAY
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NIB_W*NUM_PATHS-1:0]   din,
    input  logic [CODE_W-1:0]            len_code,
    input  logic                         pin_mode,
    output logic [NIB_W*NUM_PATHS-1:0]   dout
);

    localparam int MAX_DELAY = MIN_DELAY + (2 ** CODE_W) - 1;
    localparam int CHAIN_LEN = MAX_DELAY - 1;
    localparam int IDX_W     = $clog2(CHAIN_LEN);
    localparam int BASE_IDX  = MIN_DELAY - 2;

    logic [CODE_W-1:0] code_q;
    dtl_mode_e         mode_q;
    logic [IDX_W-1:0]  code_sel;

    logic [NUM_PATHS-1:0][CHAIN_LEN-1:0][NIB_W-1:0] stages;

    dtl_ctrl_reg #(
        .CODE_W (CODE_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (len_code),
        .mode_in (pin_mode),
        .code_q  (code_q),
        .mode_q  (mode_q)
    );

    // Code N selects zero-based stage N+BASE_IDX (the N+2 th register by default)
    assign code_sel = IDX_W'(code_q) + IDX_W'(BASE_IDX);

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        logic [IDX_W-1:0] sel;

        if (p == NUM_PATHS - 1) begin : g_pinnable
            assign sel = (mode_q == MODE_PIN_UPPER) ? IDX_W'(CHAIN_LEN - 1) : code_sel;
        end else begin : g_coded
            assign sel = code_sel;
        end

        dtl_chain #(
            .W   (NIB_W),
            .LEN (CHAIN_LEN)
        ) u_chain (
            .clk     (clk),
            .rst_n   (rst_n),
            .lane_in (din[p*NIB_W +: NIB_W]),
            .stages  (stages[p])
        );

        dtl_tap_out #(
            .W     (NIB_W),
            .LEN   (CHAIN_LEN),
            .IDX_W (IDX_W)
        ) u_tap (
            .clk      (clk),
            .rst_n    (rst_n),
            .stages   (stages[p]),
            .sel      (sel),
            .lane_out (dout[p*NIB_W +: NIB_W])
        );
    end

endmodule

// File: rtl/dtl_delay_line_chk.sv
module dtl_delay_line_chk #(
    parameter int NIB_W     = 4,
    parameter int NUM_PATHS = 2,
    parameter int CODE_W    = 4,
    parameter int CHAIN_LEN = 17
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic [NIB_W*NUM_PATHS-1:0]                   din,
    input logic [CODE_W-1:0]                            len_code,
    input logic                                         pin_mode,
    input logic [NIB_W*NUM_PATHS-1:0]                   dout,
    input logic [CODE_W-1:0]                            code_q,
    input logic                                         mode_q,
    input logic [NUM_PATHS-1:0][CHAIN_LEN-1:0][NIB_W-1:0] stages
);

    localparam int WARM = CHAIN_LEN + 3;
    localparam int WW   = $clog2(WARM + 1);

    logic [WW-1:0] warm_cnt;
    logic          warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_cnt <= '0;
        end else if (int'(warm_cnt) < WARM) begin
            warm_cnt <= warm_cnt + 1'b1;
        end
    end

    assign warm = (int'(warm_cnt) == WARM);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (dout == '0 && code_q == '0 && mode_q == 1'b0));

    // R3
    min_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(code_q) == '0) |-> dout[NIB_W-1:0] == $past(din[NIB_W-1:0], 3));

    // R4
    pinned_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode_q)) |->
            dout[NIB_W*NUM_PATHS-1 -: NIB_W] == $past(stages[NUM_PATHS-1][CHAIN_LEN-1]));

    // R5
    ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (code_q == $past(len_code) && mode_q == $past(pin_mode)));

    // R6
    chain_undisturbed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && code_q != $past(code_q)) |->
            (stages[0][CHAIN_LEN-1] == $past(stages[0][CHAIN_LEN-2]) &&
             stages[NUM_PATHS-1][0] == $past(din[NIB_W*NUM_PATHS-1 -: NIB_W])));

endmodule

bind dtl_delay_line dtl_delay_line_chk #(
    .NIB_W     (NIB_W),
    .NUM_PATHS (NUM_PATHS),
    .CODE_W    (CODE_W),
    .CHAIN_LEN (CHAIN_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .len_code (len_code),
    .pin_mode (pin_mode),
    .dout     (dout),
    .code_q   (code_q),
    .mode_q   (mode_q),
    .stages   (stages)
);

// File: tb/dtl_delay_line_bench.sv
module dtl_delay_line_bench;

    localparam int NCYC  = 4096;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic [3:0] len_code = '0;
    logic       pin_mode = 1'b0;
    logic [7:0] dout;

    int tests = 0;
    int fails = 0;
    int t = 0;

    logic [7:0] hist  [NCYC];
    logic [3:0] hcode [NCYC];
    logic       hmode [NCYC];

    always #10 clk = ~clk;

    dtl_delay_line u_dtl_delay_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .len_code (len_code),
        .pin_mode (pin_mode),
        .dout     (dout)
    );

    // Expected nibble of a lane after edge te, from the requirements alone
    function automatic logic [3:0] exp_nib(int te, int lane);
        int ci = te - 1;
        logic [3:0] c = (ci >= 1) ? hcode[ci] : 4'd0;
        logic       m = (ci >= 1) ? hmode[ci] : 1'b0;
        int d = (lane == 1 && m) ? 18 : int'(c) + 3;
        int src = te - (d - 1);
        if (src < 1) return 4'h0;
        return lane == 1 ? hist[src][7:4] : hist[src][3:0];
    endfunction

    function automatic string tag_of(int te, int lane);
        int ci = te - 1;
        if (ci >= 2 && (hcode[ci] != hcode[ci-1] || hmode[ci] != hmode[ci-1])) return "R5/R6";
        if (ci >= 1 && hmode[ci] && lane == 1) return "R4/R7";
        if (ci >= 1 && (hcode[ci] == 4'd0 || hcode[ci] == 4'd15)) return "R3/R7";
        return "R2/R7";
    endfunction

    task automatic check_now();
        for (int lane = 0; lane < 2; lane++) begin
            logic [3:0] e = exp_nib(t, lane);
            logic [3:0] a = lane == 1 ? dout[7:4] : dout[3:0];
            tests++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s cycle %0d lane %0d: got %h expected %h", tag_of(t, lane), t, lane, a, e);
            end
        end
    endtask

    task automatic step(logic [7:0] d, logic [3:0] c, logic m);
        hist[t+1]  = d;
        hcode[t+1] = c;
        hmode[t+1] = m;
        din      = d;
        len_code = c;
        pin_mode = m;
        @(posedge clk);
        @(negedge clk);
        t++;
        check_now();
    endtask

    initial begin
        int hold;
        logic [3:0] rc;
        logic rm;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: cleared output while reset is held
        tests++;
        if (dout !== 8'h00) begin
            fails++;
            $display("FAIL R1 reset output: got %h expected 00", dout);
        end
        rst_n = 1'b1;
        // Directed: every code in shared mode, then in pinned mode (R2, R3, R4)
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                for (int k = 0; k < 36; k++) begin
                    step(8'($urandom()), 4'(c), m[0]);
                end
            end
        end
        // Directed corner: impulse at max then jump to min (R6)
        for (int k = 0; k < 20; k++) step(8'h00, 4'd15, 1'b0);
        step(8'hA5, 4'd15, 1'b0);
        for (int k = 0; k < 6; k++) step(8'h00, 4'd15, 1'b0);
        for (int k = 0; k < 20; k++) step(8'h00, 4'd0, 1'b0);
        // Random mid-stream changes of code and mode (R5, R6)
        rc = 4'd7;
        rm = 1'b0;
        hold = 0;
        for (int k = 0; k < 2000; k++) begin
            if (hold == 0) begin
                rc = 4'($urandom_range(15, 0));
                rm = ($urandom_range(3, 0) == 0);
                hold = $urandom_range(6, 1);
            end
            hold--;
            step(8'($urandom()), rc, rm);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", t);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule